// File: doc/BRIEF.md
# Two-Stage Pipelined Hybrid Adder

This block adds two 64-bit operands and a carry input. It takes a new operand pair on every clock and returns the 65-bit total (64 sum bits plus a carry-out) two clock edges later. The datapath is cut into eight byte slices. Each slice builds its half-sum bits and resolves its internal carry chain twice, once for an incoming carry of 0 and once for 1. The slice results are registered at the first pipeline boundary.

In the second stage the four low slices get their carry-ins from a two-level sum-of-products lookahead network driven by the registered carry input. The four high slices form a conditional chain that is evaluated for both possible carries into bit 32. The carry out of the low half then selects one of those two outcomes for the whole upper half. Each sum bit is one XOR of the registered half-sum with the chosen carry, and it is captured in the output register.

A valid flag travels beside the data. Only that flag is cleared by reset; the data registers load only when their stage holds valid work.

Top module: `hadd_pipe`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, and it stays 0 after reset until a valid input has had time to reach the output.
- R2: `out_valid` is high in exactly those cycles that follow, by two rising clock edges, an edge at which `in_valid` was sampled high.
- R3: When `out_valid` is high, `{out_cout, out_sum}` equals `in_a + in_b + in_cin`, computed to 65 bits, for the operands sampled two edges earlier.
- R4: Operand pairs may be presented on consecutive cycles with no gap, and results come out one per cycle in the order of entry.
- R5: A carry produced in the low 32 bits that leaves bit 31 reaches bit 32 and beyond (for example 0x00000000_FFFFFFFF + 1 = 0x00000001_00000000).
- R6: With operands that propagate at every bit (`in_b` equal to the bitwise inverse of `in_a`), the result is all ones with carry-out 0 when `in_cin` is 0, and all zeros with carry-out 1 when `in_cin` is 1.
- R7: A carry crossing a byte boundary inside the low 32 bits is resolved correctly (for example 0xFF + 0x01 = 0x100, and 0x00FFFFFF + 1 = 0x01000000).
- R8: In a cycle where `out_valid` is low and an earlier result exists, `out_sum` and `out_cout` keep the value of the most recent result.
- R9: `in_cin` adds one at bit 0 (for example 0 + 0 with `in_cin` = 1 gives sum 1, carry-out 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset; clears the valid pipeline only |
| in_valid | input | 1 | Operand pair and carry input are valid this cycle |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_cin | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | Result valid, two edges after the matching input |
| out_sum | output | 64 | Sum bits of the result |
| out_cout | output | 1 | Carry out of bit 63 |

## Verification
The hardest case to reach is a carry that has to pass through every byte and across the boundary between the lookahead half and the select half. Random operands almost never propagate at all 64 bits. To reach it, the stimulus mixes in operand pairs where one operand is the inverse of the other, with a random carry input. It also uses pairs with long runs of ones that end near byte and half-word boundaries. Directed cases hit the bit-31 to bit-32 crossing and the full-width wrap with both carry-input values. Random bubbles in the valid stream exercise the hold behaviour of the output registers.

// File: rtl/hadd_pkg.sv
package hadd_pkg;
  // Default geometry of the adder
  localparam int unsigned HADD_DATA_W  = 64;
  localparam int unsigned HADD_SLICE_W = 8;
endpackage

// File: rtl/hadd_slice.sv
// One byte slice: half-sum bits plus two carry chains (incoming carry 0 / 1).
module hadd_slice #(
  parameter int unsigned W = hadd_pkg::HADD_SLICE_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] half_sum,
  output logic [W-1:0] cin_vec0,   // carry into each bit, slice carry-in = 0
  output logic [W-1:0] cin_vec1,   // carry into each bit, slice carry-in = 1
  output logic         gen_out,    // slice carry-out assuming carry-in 0
  output logic         xmit_out    // slice carry-out assuming carry-in 1 (not killed)
);
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic         run0;
  logic         run1;

  always_comb begin
    bit_g = op_a & op_b;
    bit_p = op_a ^ op_b;
    run0  = 1'b0;
    run1  = 1'b1;
    for (int i = 0; i < W; i++) begin
      cin_vec0[i] = run0;
      cin_vec1[i] = run1;
      run0 = bit_g[i] | (bit_p[i] & run0);
      run1 = bit_g[i] | (bit_p[i] & run1);
    end
    half_sum = bit_p;
    gen_out  = run0;
    xmit_out = run1;
  end
endmodule

// File: rtl/hadd_cla.sv
// Lookahead network: each slice carry-in as a flat sum of products.
module hadd_cla #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] grp_gen,
  input  logic [N-1:0] grp_xmit,
  input  logic         carry_in,
  output logic [N-1:0] slice_cin,
  output logic         carry_out
);
  logic [N:0] cv;
  logic       pass_all;
  logic       acc;

  always_comb begin
    for (int j = 0; j <= N; j++) begin
      pass_all = 1'b1;
      acc      = 1'b0;
      for (int k = j - 1; k >= 0; k--) begin
        acc      = acc | (pass_all & grp_gen[k]);
        pass_all = pass_all & grp_xmit[k];
      end
      cv[j] = acc | (pass_all & carry_in);
    end
    slice_cin = cv[N-1:0];
    carry_out = cv[N];
  end
endmodule

// File: rtl/hadd_csel.sv
// Conditional chain over the upper slices, evaluated for both half carry-ins.
module hadd_csel #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] grp_gen,
  input  logic [N-1:0] grp_xmit,
  output logic [N-1:0] cin_if0,
  output logic [N-1:0] cin_if1,
  output logic         cout_if0,
  output logic         cout_if1
);
  logic r0;
  logic r1;

  always_comb begin
    r0 = 1'b0;
    r1 = 1'b1;
    for (int i = 0; i < N; i++) begin
      cin_if0[i] = r0;
      cin_if1[i] = r1;
      r0 = r0 ? grp_xmit[i] : grp_gen[i];
      r1 = r1 ? grp_xmit[i] : grp_gen[i];
    end
    cout_if0 = r0;
    cout_if1 = r1;
  end
endmodule

// File: rtl/hadd_pipe.sv
// Two-stage hybrid adder: byte slices -> register -> lookahead/select/XOR -> register.
module hadd_pipe #(
  parameter int unsigned DATA_W  = hadd_pkg::HADD_DATA_W,
  parameter int unsigned SLICE_W = hadd_pkg::HADD_SLICE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_cin,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sum,
  output logic              out_cout
);
  localparam int unsigned NSL = DATA_W / SLICE_W;
  localparam int unsigned LSL = NSL / 2;
  localparam int unsigned HSL = NSL - LSL;

  // ---------------- stage 1: byte slices ----------------
  logic [DATA_W-1:0] hs_d, cy0_d, cy1_d;
  logic [NSL-1:0]    gen_d, xmit_d;

  for (genvar s = 0; s < NSL; s++) begin : g_slice
    hadd_slice #(.W(SLICE_W)) u_slice (
      .op_a     (in_a [s*SLICE_W +: SLICE_W]),
      .op_b     (in_b [s*SLICE_W +: SLICE_W]),
      .half_sum (hs_d [s*SLICE_W +: SLICE_W]),
      .cin_vec0 (cy0_d[s*SLICE_W +: SLICE_W]),
      .cin_vec1 (cy1_d[s*SLICE_W +: SLICE_W]),
      .gen_out  (gen_d[s]),
      .xmit_out (xmit_d[s])
    );
  end

  logic              s1_valid;
  logic [DATA_W-1:0] s1_hs, s1_cy0, s1_cy1;
  logic [NSL-1:0]    s1_gen, s1_xmit;
  logic              s1_cin;
  logic              s1_load;

  assign s1_load = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_hs   <= hs_d;
      s1_cy0  <= cy0_d;
      s1_cy1  <= cy1_d;
      s1_gen  <= gen_d;
      s1_xmit <= xmit_d;
      s1_cin  <= in_cin;
    end
  end

  // ---------------- stage 2: carries, select, XOR ----------------
  logic [LSL-1:0] lo_cin;
  logic           lo_cout;
  logic [HSL-1:0] hi_cin0, hi_cin1;
  logic           hi_cout0, hi_cout1;

  hadd_cla #(.N(LSL)) u_cla (
    .grp_gen   (s1_gen [LSL-1:0]),
    .grp_xmit  (s1_xmit[LSL-1:0]),
    .carry_in  (s1_cin),
    .slice_cin (lo_cin),
    .carry_out (lo_cout)
  );

  hadd_csel #(.N(HSL)) u_csel (
    .grp_gen  (s1_gen [NSL-1:LSL]),
    .grp_xmit (s1_xmit[NSL-1:LSL]),
    .cin_if0  (hi_cin0),
    .cin_if1  (hi_cin1),
    .cout_if0 (hi_cout0),
    .cout_if1 (hi_cout1)
  );

  logic [NSL-1:0]    slc_cin;
  logic [DATA_W-1:0] sum_d;
  logic              cout_d;

  always_comb begin
    slc_cin = {(lo_cout ? hi_cin1 : hi_cin0), lo_cin};
    cout_d  = lo_cout ? hi_cout1 : hi_cout0;
  end

  for (genvar s = 0; s < NSL; s++) begin : g_xor
    assign sum_d[s*SLICE_W +: SLICE_W] = s1_hs[s*SLICE_W +: SLICE_W] ^
      (slc_cin[s] ? s1_cy1[s*SLICE_W +: SLICE_W] : s1_cy0[s*SLICE_W +: SLICE_W]);
  end

  logic s2_load;
  assign s2_load = s1_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s2_load) begin
      out_sum  <= sum_d;
      out_cout <= cout_d;
    end
  end
endmodule

// File: rtl/hadd_pipe_chk.sv
module hadd_pipe_chk #(
  parameter int unsigned DATA_W = hadd_pkg::HADD_DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              in_cin,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_sum,
  input logic              out_cout
);
  localparam int unsigned DW1 = DATA_W + 1;

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc <= 2'd0;
    else if (cyc != 2'd3)  cyc <= cyc + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_rst_clear_R1: assert (!out_valid)
        else $error("out_valid high during reset");
    end
  end

  assert_vld_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (out_valid == $past(in_valid, 2)));

  assert_sum_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && out_valid) |->
      ({out_cout, out_sum} == (DW1'($past(in_a, 2)) + DW1'($past(in_b, 2)) + DW1'($past(in_cin, 2)))));

  assert_hold_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && !out_valid) |-> ($stable(out_sum) && $stable(out_cout)));
endmodule

bind hadd_pipe hadd_pipe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .in_cin(in_cin), .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout)
);

// File: tb/sim_hadd_pipe.sv
`timescale 1ns/1ps
module sim_hadd_pipe;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_a, in_b;
  logic        in_cin;
  logic        out_valid;
  logic [63:0] out_sum;
  logic        out_cout;

  always #2.5 clk = ~clk;   // 200 MHz

  hadd_pipe u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_cin(in_cin), .out_valid(out_valid), .out_sum(out_sum), .out_cout(out_cout)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  string       cur_tag;
  logic [64:0] expq[$];
  string       tagq[$];
  logic [1:0]  vh;
  bit          have_prev = 1'b0;
  logic [64:0] prev_res;

  function automatic logic [64:0] ref_add(logic [63:0] a, logic [63:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {64'd0, c};
  endfunction

  task automatic chk(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic send(logic [63:0] a, logic [63:0] b, logic c, string tg);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_cin = c; cur_tag = tg;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
  endtask

  // record inputs on the edge that samples them
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) vh <= 2'b00;
    else begin
      vh <= {vh[0], in_valid};
      if (in_valid) begin
        expq.push_back(ref_add(in_a, in_b, in_cin));
        tagq.push_back(cur_tag);
      end
    end
  end

  // sample outputs mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(out_valid == 1'b0, "R1 valid in reset", {64'd0, out_valid}, 65'd0);
    end else begin
      chk(out_valid == vh[1], "R2 valid timing", {64'd0, out_valid}, {64'd0, vh[1]});
      if (out_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected result", {out_cout, out_sum}, 65'd0);
        end else begin
          logic [64:0] e;
          string       t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk({out_cout, out_sum} == e, t, {out_cout, out_sum}, e);
        end
        have_prev = 1'b1;
        prev_res  = {out_cout, out_sum};
      end else if (have_prev) begin
        chk({out_cout, out_sum} == prev_res, "R8 hold on bubble", {out_cout, out_sum}, prev_res);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog expired", 65'd0, 65'd0);
    report();
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd20240611);
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_cin = 1'b0; cur_tag = "R3";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();   // R1: still no valid output

    // directed corners
    send(64'h0, 64'h0, 1'b1, "R9 carry input alone");
    send(64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, "R5 bit31 to bit32");
    send(64'h0000_0000_FFFF_FFFF, 64'h0, 1'b1, "R5 cin through low half");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R6 full wrap cin=1");
    send(64'h5A5A_A5A5_0F0F_F0F0, ~64'h5A5A_A5A5_0F0F_F0F0, 1'b0, "R6 all propagate cin=0");
    send(64'h5A5A_A5A5_0F0F_F0F0, ~64'h5A5A_A5A5_0F0F_F0F0, 1'b1, "R6 all propagate cin=1");
    send(64'hFF, 64'h1, 1'b0, "R7 byte boundary");
    send(64'h00FF_FFFF, 64'h1, 1'b0, "R7 three-byte run");
    send(64'h00FF_FFFF_FFFF_FFFF, 64'h1, 1'b0, "R5 run into high half");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R3 max operands");
    idle(); idle(); idle();

    // R4: back-to-back burst
    for (int i = 0; i < 40; i++)
      send({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R4 back-to-back");

    // mixed constrained random with bubbles
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a;
      int unsigned m;
      a = {$urandom, $urandom};
      m = $urandom % 5;
      case (m)
        0: send(a, {$urandom, $urandom}, 1'($urandom), "R3 random");
        1: send(a, ~a, 1'($urandom), "R6 random propagate");
        2: send((64'h1 << ($urandom % 64)) - 64'h1, 64'h1 << ($urandom % 8), 1'($urandom),
                "R7 ones run");
        3: send(a, ~a ^ (64'h1 << ($urandom % 64)), 1'($urandom), "R3 near propagate");
        default: idle();
      endcase
    end
    repeat (5) idle();
    chk(expq.size() == 0, "R4 all results delivered", 65'(expq.size()), 65'd0);

    // reset mid-stream: valid pipeline clears
    send(64'h1234, 64'h1, 1'b0, "R3 before reset");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    expq.delete(); tagq.delete();
    @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();
    send(64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b1, "R5 after reset");
    repeat (4) idle();
    report();
  end
endmodule